// File: doc/BRIEF.md
# Snapshot Event Counter Bank

This block sits on an 8-bit processor bus and keeps running totals of four kinds of activity: enabled clock cycles, retired instructions, maskable interrupt events and non-maskable interrupt events. Each total is held in a 64-bit live counter. A separate time base accumulates elapsed nanoseconds from an increment input. The time base is kept in two forms: one plain 64-bit nanosecond total, and one split form that holds whole seconds in one half and the nanoseconds within the current second in the other half.

Software cannot read a live value directly. A single write to the snapshot register copies every live value into its own shadow register on the same clock edge, so all shadow registers describe the same moment. A view register then chooses which shadow appears in an eight-byte read-only window. The view codes are sparse. A code that the block does not define makes the window read as zero. The real-time source and the processor core are outside the block.

Top module: `evt_snapshot_regs`

## Requirements
- R1: After reset the view register reads 0x00 and every shadow register is zero. Until the first snapshot write, every window byte reads 0x00 for every view code.
- R2: The cycle counter adds one on each clock edge at which `clk_en` is high and holds otherwise. View code 0x00 shows its shadow.
- R3: The instruction, maskable-interrupt and non-maskable-interrupt counters each add one per cycle in which their strobe is high. View codes 0x01, 0x02 and 0x03 show their shadows, in that order.
- R4: A write of any data to offset 0 (address `BASE_ADDR`) copies all live values into their shadows on the same edge. The shadows keep those values until the next such write, whatever the live counters do in between.
- R5: A strobe or `clk_en` that is high in the same cycle as a snapshot write is not included in the captured value. It shows up in the next snapshot.
- R6: Offsets 2 to 9 form the read window. Offset 2 returns bits 7:0 of the selected shadow, and each following offset returns the next byte up, so offset 9 returns bits 63:56.
- R7: View code 0x80 shows the captured plain nanosecond total, which is the sum of all `ns_step` values applied since reset.
- R8: View code 0x81 shows the captured split time: whole seconds in bits 63:32 and nanoseconds within the second in bits 31:0. The nanosecond field wraps at `NS_PER_SEC` and carries one into the seconds field, and reaching exactly `NS_PER_SEC` wraps it to 0. Both time forms are captured at the same instant.
- R9: The view register (offset 1) stores and reads back all 8 written bits. Any value other than 0x00–0x03, 0x80 or 0x81 makes all eight window bytes read 0x00.
- R10: A read of offset 0 returns 0x00. Writes to offsets 2 to 9 change no register, and the window keeps its contents.
- R11: `bus_rdata` is 0x00 when `bus_rd` is low and when the address lies outside offsets 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wr | input | 1 | Write strobe, acted on at the clock edge |
| bus_rdata | output | 8 | Read data |
| clk_en | input | 1 | Counts one enabled cycle |
| instr_ev | input | 1 | Single-cycle retired-instruction strobe |
| irq_ev | input | 1 | Single-cycle maskable-interrupt strobe |
| nmi_ev | input | 1 | Single-cycle non-maskable-interrupt strobe |
| ns_step | input | STEP_W | Nanoseconds to add to the time base this cycle, below NS_PER_SEC |

## Verification
The bench builds the block with `NS_PER_SEC` set to 100 and `STEP_W` set to 8. All other parameters keep their defaults, so the window is 64 bits wide and sits at 0xFFC0. With the small second length, a few dozen stimulus cycles are enough to reach a seconds carry, an exact wrap of the nanosecond field to zero, and a step that stops just below the limit. Two checks together cover R6: a cycle count above 255 puts non-zero data into two bytes, and the upper bytes are read back as zero.

// File: rtl/evtsnap_pkg.sv
package evtsnap_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_EVT   = 4;

    // live counter slots
    localparam int EV_CYC    = 0;
    localparam int EV_INSTR  = 1;
    localparam int EV_IRQ    = 2;
    localparam int EV_NMI    = 3;

    // register offsets from the base address
    localparam int OFS_SNAP  = 0;
    localparam int OFS_VIEW  = 1;
    localparam int OFS_WIN   = 2;

    typedef enum logic [7:0] {
        VIEW_CYC       = 8'h00,
        VIEW_INSTR     = 8'h01,
        VIEW_IRQ       = 8'h02,
        VIEW_NMI       = 8'h03,
        VIEW_WALL_NS   = 8'h80,
        VIEW_WALL_SPLT = 8'h81
    } view_code_e;

endpackage

// File: rtl/evtsnap_live_counters.sv
module evtsnap_live_counters #(
    parameter int CNT_W = 64,
    parameter int NUM   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc,
    output logic [NUM-1:0][CNT_W-1:0] count
);

    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                count[g] <= '0;
            end else if (inc[g]) begin
                count[g] <= count[g] + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/evtsnap_wallclock.sv
module evtsnap_wallclock #(
    parameter int CNT_W      = 64,
    parameter int HALF       = 32,
    parameter int STEP_W     = 16,
    parameter int NS_PER_SEC = 1_000_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] ns_step,
    output logic [CNT_W-1:0]  ns_total,
    output logic [HALF-1:0]   sec,
    output logic [HALF-1:0]   frac
);

    localparam logic [HALF:0] LIMIT = (HALF+1)'(NS_PER_SEC);

    logic [HALF:0] frac_sum;
    logic          carry;

    always_comb begin
        frac_sum = (HALF+1)'(frac) + (HALF+1)'(ns_step);
        carry    = (frac_sum >= LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ns_total <= '0;
            sec      <= '0;
            frac     <= '0;
        end else begin
            ns_total <= ns_total + CNT_W'(ns_step);
            if (carry) begin
                frac <= HALF'(frac_sum - LIMIT);
                sec  <= sec + HALF'(1);
            end else begin
                frac <= HALF'(frac_sum);
            end
        end
    end

endmodule

// File: rtl/evtsnap_shadow.sv
module evtsnap_shadow #(
    parameter int CNT_W = 64,
    parameter int HALF  = 32,
    parameter int NUM   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      snap,
    input  logic [NUM-1:0][CNT_W-1:0] live_cnt,
    input  logic [CNT_W-1:0]          live_ns,
    input  logic [HALF-1:0]           live_sec,
    input  logic [HALF-1:0]           live_frac,
    output logic [NUM-1:0][CNT_W-1:0] held_cnt,
    output logic [CNT_W-1:0]          held_ns,
    output logic [HALF-1:0]           held_sec,
    output logic [HALF-1:0]           held_frac
);

    for (genvar g = 0; g < NUM; g++) begin : g_hold
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held_cnt[g] <= '0;
            end else if (snap) begin
                held_cnt[g] <= live_cnt[g];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_ns   <= '0;
            held_sec  <= '0;
            held_frac <= '0;
        end else if (snap) begin
            held_ns   <= live_ns;
            held_sec  <= live_sec;
            held_frac <= live_frac;
        end
    end

endmodule

// File: rtl/evtsnap_readout.sv
module evtsnap_readout
    import evtsnap_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int HALF  = 32,
    parameter int IDX_W = 3
) (
    input  logic [7:0]                    view,
    input  logic [NUM_EVT-1:0][CNT_W-1:0] held_cnt,
    input  logic [CNT_W-1:0]              held_ns,
    input  logic [HALF-1:0]               held_sec,
    input  logic [HALF-1:0]               held_frac,
    input  logic [IDX_W-1:0]              byte_idx,
    output logic [BYTE_W-1:0]             byte_out
);

    logic [CNT_W-1:0] word;

    always_comb begin
        case (view)
            VIEW_CYC:       word = held_cnt[EV_CYC];
            VIEW_INSTR:     word = held_cnt[EV_INSTR];
            VIEW_IRQ:       word = held_cnt[EV_IRQ];
            VIEW_NMI:       word = held_cnt[EV_NMI];
            VIEW_WALL_NS:   word = held_ns;
            VIEW_WALL_SPLT: word = {held_sec, held_frac};
            default:        word = '0;
        endcase
        byte_out = word[byte_idx*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/evt_snapshot_regs.sv
module evt_snapshot_regs
    import evtsnap_pkg::*;
#(
    parameter int          CNT_W      = 64,
    parameter int          ADDR_W     = 16,
    parameter int unsigned BASE_ADDR  = 32'hFFC0,
    parameter int          NS_PER_SEC = 1_000_000_000,
    parameter int          STEP_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    input  logic              clk_en,
    input  logic              instr_ev,
    input  logic              irq_ev,
    input  logic              nmi_ev,
    input  logic [STEP_W-1:0] ns_step
);

    localparam int HALF      = CNT_W / 2;
    localparam int WIN_BYTES = CNT_W / BYTE_W;
    localparam int IDX_W     = $clog2(WIN_BYTES);
    localparam int SPAN      = OFS_WIN + WIN_BYTES;

    // address decode
    logic [ADDR_W-1:0] ofs;
    logic              hit;
    logic              snap_req;
    logic              view_wr;
    logic [IDX_W-1:0]  win_idx;

    assign ofs      = bus_addr - ADDR_W'(BASE_ADDR);
    assign hit      = (ofs < ADDR_W'(SPAN));
    assign snap_req = bus_wr && (ofs == ADDR_W'(OFS_SNAP));
    assign view_wr  = bus_wr && (ofs == ADDR_W'(OFS_VIEW));
    assign win_idx  = IDX_W'(ofs - ADDR_W'(OFS_WIN));

    // view register
    logic [7:0] view_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            view_q <= 8'h00;
        end else if (view_wr) begin
            view_q <= bus_wdata;
        end
    end

    // live values
    logic [NUM_EVT-1:0]            inc;
    logic [NUM_EVT-1:0][CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0]              wall_ns;
    logic [HALF-1:0]               wall_sec;
    logic [HALF-1:0]               wall_frac;

    always_comb begin
        inc           = '0;
        inc[EV_CYC]   = clk_en;
        inc[EV_INSTR] = instr_ev;
        inc[EV_IRQ]   = irq_ev;
        inc[EV_NMI]   = nmi_ev;
    end

    evtsnap_live_counters #(
        .CNT_W (CNT_W),
        .NUM   (NUM_EVT)
    ) u_live (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc),
        .count (live_cnt)
    );

    evtsnap_wallclock #(
        .CNT_W      (CNT_W),
        .HALF       (HALF),
        .STEP_W     (STEP_W),
        .NS_PER_SEC (NS_PER_SEC)
    ) u_wall (
        .clk      (clk),
        .rst_n    (rst_n),
        .ns_step  (ns_step),
        .ns_total (wall_ns),
        .sec      (wall_sec),
        .frac     (wall_frac)
    );

    // shadow registers
    logic [NUM_EVT-1:0][CNT_W-1:0] held_cnt;
    logic [CNT_W-1:0]              held_ns;
    logic [HALF-1:0]               held_sec;
    logic [HALF-1:0]               held_frac;

    evtsnap_shadow #(
        .CNT_W (CNT_W),
        .HALF  (HALF),
        .NUM   (NUM_EVT)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap      (snap_req),
        .live_cnt  (live_cnt),
        .live_ns   (wall_ns),
        .live_sec  (wall_sec),
        .live_frac (wall_frac),
        .held_cnt  (held_cnt),
        .held_ns   (held_ns),
        .held_sec  (held_sec),
        .held_frac (held_frac)
    );

    // read path
    logic [7:0] win_byte;

    evtsnap_readout #(
        .CNT_W (CNT_W),
        .HALF  (HALF),
        .IDX_W (IDX_W)
    ) u_read (
        .view      (view_q),
        .held_cnt  (held_cnt),
        .held_ns   (held_ns),
        .held_sec  (held_sec),
        .held_frac (held_frac),
        .byte_idx  (win_idx),
        .byte_out  (win_byte)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd && hit) begin
            if (ofs == ADDR_W'(OFS_SNAP)) begin
                bus_rdata = 8'h00;
            end else if (ofs == ADDR_W'(OFS_VIEW)) begin
                bus_rdata = view_q;
            end else begin
                bus_rdata = win_byte;
            end
        end
    end

endmodule

// File: rtl/evtsnap_checker.sv
module evtsnap_checker #(
    parameter int          CNT_W      = 64,
    parameter int          HALF       = 32,
    parameter int          ADDR_W     = 16,
    parameter int unsigned BASE_ADDR  = 32'hFFC0,
    parameter int          NS_PER_SEC = 1_000_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_rdata,
    input logic              clk_en,
    input logic [CNT_W-1:0]  live_cyc,
    input logic [CNT_W-1:0]  live_instr,
    input logic [CNT_W-1:0]  held_cyc,
    input logic [CNT_W-1:0]  held_instr,
    input logic [CNT_W-1:0]  held_ns,
    input logic [HALF-1:0]   held_sec,
    input logic [HALF-1:0]   held_frac
);

    logic snap_seen;
    assign snap_seen = bus_wr && (bus_addr == ADDR_W'(BASE_ADDR));

    a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (held_cyc == '0 && held_instr == '0 && held_ns == '0));

    a_r2_cyc_counts: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> live_cyc == $past(live_cyc) + CNT_W'(1));

    a_r2_cyc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(live_cyc));

    a_r4_shadow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_seen |=> ($stable(held_cyc) && $stable(held_instr) && $stable(held_ns)
                        && $stable(held_sec) && $stable(held_frac)));

    a_r5_pre_increment: assert property (@(posedge clk) disable iff (!rst_n)
        snap_seen |=> (held_cyc == $past(live_cyc) && held_instr == $past(live_instr)));

    a_r8_frac_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        held_frac < HALF'(NS_PER_SEC));

    a_r8_same_instant: assert property (@(posedge clk) disable iff (!rst_n)
        held_ns == CNT_W'(held_sec) * CNT_W'(NS_PER_SEC) + CNT_W'(held_frac));

    a_r10_snap_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(BASE_ADDR)) |-> bus_rdata == 8'h00);

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == 8'h00);

endmodule

bind evt_snapshot_regs evtsnap_checker #(
    .CNT_W      (CNT_W),
    .HALF       (CNT_W / 2),
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .NS_PER_SEC (NS_PER_SEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .clk_en     (clk_en),
    .live_cyc   (live_cnt[0]),
    .live_instr (live_cnt[1]),
    .held_cyc   (held_cnt[0]),
    .held_instr (held_cnt[1]),
    .held_ns    (held_ns),
    .held_sec   (held_sec),
    .held_frac  (held_frac)
);

// File: tb/sim_evt_snapshot_regs.sv
module sim_evt_snapshot_regs;

    localparam int ADDR_W = 16;
    localparam int STEP_W = 8;
    localparam logic [15:0] BASE = 16'hFFC0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_rdata;
    logic              clk_en = 1'b0;
    logic              instr_ev = 1'b0;
    logic              irq_ev = 1'b0;
    logic              nmi_ev = 1'b0;
    logic [STEP_W-1:0] ns_step = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evt_snapshot_regs #(
        .CNT_W      (64),
        .ADDR_W     (ADDR_W),
        .BASE_ADDR  (32'hFFC0),
        .NS_PER_SEC (100),
        .STEP_W     (STEP_W)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .clk_en    (clk_en),
        .instr_ev  (instr_ev),
        .irq_ev    (irq_ev),
        .nmi_ev    (nmi_ev),
        .ns_step   (ns_step)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #2;
        d      = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic read_window(output logic [63:0] v);
        logic [7:0] b;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            bus_read(BASE + 16'(2 + i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic snapshot();
        bus_write(BASE, 8'h5A);
    endtask

    task automatic view_check(input string tag, input logic [7:0] code, input logic [63:0] exp);
        logic [63:0] v;
        bus_write(BASE + 16'd1, code);
        read_window(v);
        check(tag, v, exp);
    endtask

    task automatic pulse(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (which)
                1: instr_ev = 1'b1;
                2: irq_ev   = 1'b1;
                default: nmi_ev = 1'b1;
            endcase
            @(negedge clk);
            instr_ev = 1'b0;
            irq_ev   = 1'b0;
            nmi_ev   = 1'b0;
        end
    endtask

    task automatic run_enabled(input int n);
        @(negedge clk);
        clk_en = 1'b1;
        repeat (n) @(negedge clk);
        clk_en = 1'b0;
    endtask

    task automatic run_steps(input logic [7:0] step, input int n);
        @(negedge clk);
        ns_step = step;
        repeat (n) @(negedge clk);
        ns_step = '0;
    endtask

    task automatic t_reset();
        logic [7:0] b;
        bus_read(BASE + 16'd1, b);
        check("R1 view after reset", 64'(b), 64'h0);
        view_check("R1 cyc before snapshot", 8'h00, 64'h0);
        view_check("R1 nmi before snapshot", 8'h03, 64'h0);
        view_check("R1 wall ns before snapshot", 8'h80, 64'h0);
        view_check("R1 wall split before snapshot", 8'h81, 64'h0);
    endtask

    task automatic t_cycles();
        logic [7:0] b;
        logic [63:0] v;
        run_enabled(300);
        snapshot();
        bus_write(BASE + 16'd1, 8'h00);
        bus_read(BASE + 16'd2, b);
        check("R6 low byte at offset 2", 64'(b), 64'h2C);
        bus_read(BASE + 16'd3, b);
        check("R6 second byte at offset 3", 64'(b), 64'h01);
        bus_read(BASE + 16'd9, b);
        check("R6 top byte at offset 9", 64'(b), 64'h00);
        read_window(v);
        check("R2 cycle count 300", v, 64'd300);
    endtask

    task automatic t_events();
        pulse(1, 5);
        pulse(2, 3);
        pulse(3, 7);
        snapshot();
        view_check("R3 instr count", 8'h01, 64'd5);
        view_check("R3 irq count", 8'h02, 64'd3);
        view_check("R3 nmi count", 8'h03, 64'd7);
        view_check("R4 cyc captured with events", 8'h00, 64'd300);
    endtask

    task automatic t_frozen();
        pulse(1, 4);
        run_enabled(10);
        view_check("R4 instr frozen", 8'h01, 64'd5);
        view_check("R4 cyc frozen", 8'h00, 64'd300);
        snapshot();
        view_check("R4 instr after new snapshot", 8'h01, 64'd9);
        view_check("R4 cyc after new snapshot", 8'h00, 64'd310);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        bus_addr = BASE;
        bus_wr   = 1'b1;
        instr_ev = 1'b1;
        @(negedge clk);
        bus_wr   = 1'b0;
        instr_ev = 1'b0;
        view_check("R5 strobe with snapshot excluded", 8'h01, 64'd9);
        snapshot();
        view_check("R5 strobe in next snapshot", 8'h01, 64'd10);
    endtask

    task automatic t_wall();
        run_steps(8'd30, 7);
        snapshot();
        view_check("R7 ns total 210", 8'h80, 64'd210);
        view_check("R8 split 2 s 10 ns", 8'h81, {32'd2, 32'd10});
        run_steps(8'd90, 1);
        snapshot();
        view_check("R7 ns total 300", 8'h80, 64'd300);
        view_check("R8 exact wrap to zero", 8'h81, {32'd3, 32'd0});
        run_steps(8'd99, 1);
        snapshot();
        view_check("R8 just below limit", 8'h81, {32'd3, 32'd99});
        view_check("R7 ns total 399", 8'h80, 64'd399);
    endtask

    task automatic t_unlisted();
        logic [7:0] codes [4] = '{8'h04, 8'h7F, 8'h82, 8'hFF};
        logic [7:0] b;
        logic [63:0] v;
        for (int i = 0; i < 4; i++) begin
            bus_write(BASE + 16'd1, codes[i]);
            bus_read(BASE + 16'd1, b);
            check("R9 view readback", 64'(b), 64'(codes[i]));
            read_window(v);
            check("R9 unlisted view reads zero", v, 64'h0);
        end
    endtask

    task automatic t_ignored();
        logic [7:0] b;
        bus_write(BASE + 16'd1, 8'h00);
        bus_write(BASE + 16'd5, 8'hAA);
        bus_write(BASE + 16'd2, 8'h55);
        view_check("R10 window writes ignored", 8'h00, 64'd310);
        bus_read(BASE, b);
        check("R10 snapshot register reads zero", 64'(b), 64'h0);
        @(negedge clk);
        bus_addr = BASE + 16'd2;
        bus_rd   = 1'b0;
        #2;
        check("R11 no read strobe gives zero", 64'(bus_rdata), 64'h0);
        bus_read(16'h1234, b);
        check("R11 foreign address reads zero", 64'(b), 64'h0);
        bus_read(BASE + 16'd10, b);
        check("R11 address past window reads zero", 64'(b), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cycles();
        t_events();
        t_frozen();
        t_same_cycle();
        t_wall();
        t_unlisted();
        t_ignored();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule